// File: doc/BRIEF.md
# Island ID Address Decoder

This block works out which destination island a fabric address reaches once the address is routed through one of four translation modes. Each request carries a 40-bit address, a 4-bit target code, a 3-bit translation mode, a flag that selects 40-bit or 32-bit address layout, and two configured base island IDs: a low one and a high one. The block reports the 6-bit island the hardware would steer the request to. Whether that island actually exists is left to the caller.

Every mode uses an index bit. This is address bit 39 in 40-bit layout and bit 31 in 32-bit layout. Mode 0 ignores the index bit and reads the island straight out of the six address bits that end at the index position. Mode 1 uses the index bit to choose between the two base IDs. Modes 2 and 3 choose a base ID in the same way, clear its lowest one or two bits, and fill them from the address bits just below the index bit. Two target codes are not decoded by this block, and mode codes above 3 are not defined. Both cases raise an error.

The unit is a single registered stage. A request taken with `valid_i` produces its result with `valid_o` on the next clock.

Top module: `isl_route_dec`

## Requirements
- R1: In mode 0 the island is address bits 39:34 when `wide_i`=1, and address bits 31:26 when `wide_i`=0.
- R2: In mode 1 the island is `isl_hi_i` when the index bit is 1 and `isl_lo_i` when it is 0. The index bit is address bit 39 when `wide_i`=1 and bit 31 when `wide_i`=0.
- R3: In mode 2 the island is the selected base ID (chosen as in R2) with bit 0 replaced by the address bit just below the index bit.
- R4: In mode 3 the island is the selected base ID with bits 1:0 replaced by the two address bits just below the index bit. The higher of those two address bits goes to island bit 1.
- R5: Target code 7 and target code 14 always give `err_o`=1. Every other target code with a mode of 3 or less gives `err_o`=0.
- R6: Any mode code from 4 to 7 gives `err_o`=1.
- R7: Whenever `err_o` is 1, `isl_o` is 0.
- R8: `valid_o` is `valid_i` delayed by exactly one clock. `err_o` and `isl_o` belong to the request taken on that same clock.
- R9: While `valid_i` is low, `err_o` and `isl_o` hold their values.
- R10: While `rst_ni` is low, `valid_o`, `err_o` and `isl_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| addr_i | input | 40 | Fabric address |
| tgt_i | input | 4 | Target code |
| mode_i | input | 3 | Translation mode |
| wide_i | input | 1 | 1 selects 40-bit layout, 0 selects 32-bit layout |
| isl_lo_i | input | 6 | Base island chosen when the index bit is 0 |
| isl_hi_i | input | 6 | Base island chosen when the index bit is 1 |
| valid_o | output | 1 | Result strobe |
| err_o | output | 1 | Target or mode refused |
| isl_o | output | 6 | Destination island |

## Verification
The bound assertions check the properties that hold on every clock. These are the one-clock strobe delay, the zero island under an error, the error for refused targets and undefined modes, the held result while no request is present, the mode 1 selection and the low-bit fill in mode 3. Only the bench's scenarios show the complete island value in each mode for both address layouts, including the cases where the index bit and the filled low bits disagree with the base IDs. The bench also drives random traffic and compares it against a behavioural model on every clock.

// File: rtl/isl_dec_pkg.sv
package isl_dec_pkg;
  localparam int ISL_W  = 6;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_FIELD = 3'd0,
    MODE_PICK  = 3'd1,
    MODE_PAIR  = 3'd2,
    MODE_QUAD  = 3'd3
  } route_mode_e;

  typedef struct packed {
    logic             err;
    logic [ISL_W-1:0] isl;
  } route_res_t;
endpackage

// File: rtl/isl_addr_taps.sv
module isl_addr_taps #(
  parameter int ADDR_W     = 40,
  parameter int ISL_W      = 6,
  parameter int NARROW_IDX = 31
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  output logic              idx_o,
  output logic [1:0]        low_o,
  output logic [ISL_W-1:0]  field_o
);
  localparam int WIDE_IDX = ADDR_W - 1;

  // taps for each layout; both end at the index position
  logic [ISL_W-1:0] fld_n, fld_w;
  logic [1:0]       low_n, low_w;

  assign fld_n = addr_i[NARROW_IDX -: ISL_W];
  assign fld_w = addr_i[WIDE_IDX -: ISL_W];
  assign low_n = addr_i[NARROW_IDX-1 -: 2];
  assign low_w = addr_i[WIDE_IDX-1 -: 2];

  assign idx_o   = wide_i ? addr_i[WIDE_IDX] : addr_i[NARROW_IDX];
  assign low_o   = wide_i ? low_w : low_n;
  assign field_o = wide_i ? fld_w : fld_n;
endmodule

// File: rtl/isl_mode_mux.sv
module isl_mode_mux
  import isl_dec_pkg::*;
#(
  parameter int TGT_W   = 4,
  parameter int MEM_TGT = 7,
  parameter int CTL_TGT = 14
) (
  input  logic [TGT_W-1:0]  tgt_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              idx_i,
  input  logic [1:0]        low_i,
  input  logic [ISL_W-1:0]  field_i,
  input  logic [ISL_W-1:0]  isl_lo_i,
  input  logic [ISL_W-1:0]  isl_hi_i,
  output route_res_t        res_o
);
  logic [ISL_W-1:0] base;
  logic             tgt_bad;

  assign base    = idx_i ? isl_hi_i : isl_lo_i;
  assign tgt_bad = (tgt_i == TGT_W'(MEM_TGT)) || (tgt_i == TGT_W'(CTL_TGT));

  always_comb begin
    res_o = '0;
    case (route_mode_e'(mode_i))
      MODE_FIELD: res_o.isl = field_i;
      MODE_PICK:  res_o.isl = base;
      MODE_PAIR:  res_o.isl = {base[ISL_W-1:1], low_i[1]};
      MODE_QUAD:  res_o.isl = {base[ISL_W-1:2], low_i};
      default:    res_o.err = 1'b1;
    endcase
    if (tgt_bad) res_o.err = 1'b1;
    if (res_o.err) res_o.isl = '0;
  end
endmodule

// File: rtl/isl_route_dec.sv
module isl_route_dec
  import isl_dec_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int TGT_W      = 4,
  parameter int NARROW_IDX = 31,
  parameter int MEM_TGT    = 7,
  parameter int CTL_TGT    = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TGT_W-1:0]  tgt_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              wide_i,
  input  logic [ISL_W-1:0]  isl_lo_i,
  input  logic [ISL_W-1:0]  isl_hi_i,
  output logic              valid_o,
  output logic              err_o,
  output logic [ISL_W-1:0]  isl_o
);
  logic             idx;
  logic [1:0]       low;
  logic [ISL_W-1:0] field;
  route_res_t       res_d, res_q;

  isl_addr_taps #(
    .ADDR_W(ADDR_W), .ISL_W(ISL_W), .NARROW_IDX(NARROW_IDX)
  ) u_taps (
    .addr_i(addr_i), .wide_i(wide_i),
    .idx_o(idx), .low_o(low), .field_o(field)
  );

  isl_mode_mux #(
    .TGT_W(TGT_W), .MEM_TGT(MEM_TGT), .CTL_TGT(CTL_TGT)
  ) u_mux (
    .tgt_i(tgt_i), .mode_i(mode_i), .idx_i(idx), .low_i(low),
    .field_i(field), .isl_lo_i(isl_lo_i), .isl_hi_i(isl_hi_i),
    .res_o(res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign err_o = res_q.err;
  assign isl_o = res_q.isl;
endmodule

// File: rtl/isl_route_dec_chk.sv
module isl_route_dec_chk #(
  parameter int ADDR_W     = 40,
  parameter int TGT_W      = 4,
  parameter int NARROW_IDX = 31,
  parameter int MEM_TGT    = 7,
  parameter int CTL_TGT    = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [TGT_W-1:0]  tgt_i,
  input logic [2:0]        mode_i,
  input logic              wide_i,
  input logic [5:0]        isl_lo_i,
  input logic [5:0]        isl_hi_i,
  input logic              valid_o,
  input logic              err_o,
  input logic [5:0]        isl_o
);
  logic       tgt_ok, ix;
  logic [1:0] lo2;
  assign tgt_ok = (tgt_i != TGT_W'(MEM_TGT)) && (tgt_i != TGT_W'(CTL_TGT));
  assign ix     = wide_i ? addr_i[ADDR_W-1] : addr_i[NARROW_IDX];
  assign lo2    = wide_i ? addr_i[ADDR_W-2 -: 2] : addr_i[NARROW_IDX-1 -: 2];

  p_err_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> isl_o == 6'd0);
  p_valid_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_bad_tgt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !tgt_ok) |=> err_o);
  p_bad_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i > 3'd3) |=> err_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(isl_o) && $stable(err_o)));
  p_pick_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && tgt_ok && mode_i == 3'd1 && ix) |=> (!err_o && isl_o == $past(isl_hi_i)));
  p_quad_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && tgt_ok && mode_i == 3'd3) |=> isl_o[1:0] == $past(lo2));
endmodule

bind isl_route_dec isl_route_dec_chk #(
  .ADDR_W(ADDR_W), .TGT_W(TGT_W), .NARROW_IDX(NARROW_IDX),
  .MEM_TGT(MEM_TGT), .CTL_TGT(CTL_TGT)
) u_chk (.*);

// File: tb/isl_route_dec_tb.sv
module isl_route_dec_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [39:0] addr_i = '0;
  logic [3:0]  tgt_i = '0;
  logic [2:0]  mode_i = '0;
  logic        wide_i = 1'b0;
  logic [5:0]  isl_lo_i = '0, isl_hi_i = '0;
  logic        valid_o, err_o;
  logic [5:0]  isl_o;

  int checks = 0, failures = 0;
  bit m_vld = 0, m_err = 0;
  int m_isl = 0;
  string cur_req = "R10";

  always #4 clk_i = ~clk_i;

  isl_route_dec u_dut (.*);

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic void model(input logic [39:0] a, input int t, input int m, input bit w,
                                input int lo, input int hi, output bit e, output int isl);
    longint unsigned ua = a;
    int ip = w ? 39 : 31;
    int b1 = (ua >> (ip - 1)) & 1;
    int b2 = (ua >> (ip - 2)) & 3;
    int sel = ((ua >> ip) & 1) ? hi : lo;
    e = (t == 7) || (t == 14) || (m > 3);
    isl = 0;
    if (!e) begin
      if (m == 0) isl = (ua >> (ip - 5)) & 63;
      else if (m == 1) isl = sel;
      else if (m == 2) isl = (sel & 62) | b1;
      else isl = (sel & 60) | b2;
    end
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: inputs set after the falling edge, model and compare after the rising edge
  task automatic step(input string req, input bit v, input logic [39:0] a, input int t,
                      input int m, input bit w, input int lo, input int hi);
    bit e; int isl;
    @(negedge clk_i);
    cur_req = req;
    valid_i = v; addr_i = a; tgt_i = 4'(t); mode_i = 3'(m); wide_i = w;
    isl_lo_i = 6'(lo); isl_hi_i = 6'(hi);
    @(posedge clk_i); #1;
    model(a, t, m, w, lo, hi, e, isl);
    m_vld = v;
    if (v) begin m_err = e; m_isl = isl; end
    check(valid_o == m_vld, {req, " R8 valid"}, valid_o, m_vld);
    check(err_o == m_err, {req, " err"}, err_o, m_err);
    check(int'(isl_o) == m_isl, {req, " isl"}, isl_o, m_isl);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check(valid_o == 0 && err_o == 0 && isl_o == 0, "R10 reset", {valid_o, err_o, isl_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    // R1 field in both layouts
    step("R1", 1, 40'h00_2C00_0000, 1, 0, 0, 5, 9);   // bits 31:26 = 11
    step("R1", 1, 40'hAC_0000_0000, 1, 0, 1, 5, 9);   // bits 39:34 = 43
    // R2 index select
    step("R2", 1, 40'h00_8000_0000, 2, 1, 0, 12, 33);
    step("R2", 1, 40'h00_7FFF_FFFF, 2, 1, 0, 12, 33);
    step("R2", 1, 40'h80_0000_0000, 2, 1, 1, 12, 33);
    step("R2", 1, 40'h7F_FFFF_FFFF, 2, 1, 1, 12, 33);
    // R3 pair fill
    step("R3", 1, 40'h00_C000_0000, 6, 2, 0, 21, 41);
    step("R3", 1, 40'h00_0000_0000, 6, 2, 0, 21, 41);
    step("R3", 1, 40'h40_0000_0000, 6, 2, 1, 21, 41);
    // R4 quad fill
    step("R4", 1, 40'h00_A000_0000, 9, 3, 0, 63, 23);
    step("R4", 1, 40'h00_6000_0000, 9, 3, 0, 63, 23);
    step("R4", 1, 40'hA0_0000_0000, 9, 3, 1, 63, 23);
    // R5, R6, R7 refusal with zero island
    step("R5", 1, 40'hFF_FFFF_FFFF, 7, 1, 0, 63, 63);
    step("R5", 1, 40'hFF_FFFF_FFFF, 14, 0, 1, 63, 63);
    step("R5", 1, 40'hFF_FFFF_FFFF, 15, 0, 1, 63, 63);
    step("R6", 1, 40'hFF_FFFF_FFFF, 1, 4, 0, 63, 63);
    step("R7", 1, 40'hFF_FFFF_FFFF, 0, 7, 1, 63, 63);
    // R9 hold while idle with changing inputs
    step("R3", 1, 40'h00_4000_0000, 3, 2, 0, 8, 8);
    step("R9", 0, 40'h00_8000_0000, 7, 5, 1, 1, 2);
    step("R9", 0, 40'h12_3456_789A, 2, 0, 0, 3, 4);
    // random traffic covering all rules
    for (int i = 0; i < 400; i++) begin
      logic [39:0] a = {$urandom(), $urandom()};
      step("R8 rand", ($urandom() % 4) != 0, a, $urandom() % 16, $urandom() % 8,
           $urandom() % 2, $urandom() % 64, $urandom() % 64);
    end
    // R10 asynchronous reset clears outputs
    @(negedge clk_i); rst_ni = 1'b0; #1;
    check(valid_o == 0 && err_o == 0 && isl_o == 0, "R10 reset again", {valid_o, err_o, isl_o}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule